// File: doc/BRIEF.md
# Delayed Register-Update Queue

This block holds a ring of pending register writes whose effect must appear a set number of ticks after they are issued. This is how latency is modelled for results such as a late-arriving load value or a condition flag. Each pending entry names a destination register, a tick delay, a value, an update kind and a size. The update kind is either a whole-register write or a single-bit set/clear.

Every tick counts all waiting entries down together. An entry that reaches its delay applies its update to a small internal register file. Storage is freed only from the head of the ring, so entries leave in the order they arrived even when a younger one matures first.

A producer pushes entries through an enqueue port and is refused while the ring is full. A separate timing source pulses the tick input. A consumer reads any register through a combinational read port. A sticky fault output reports a pointer/occupancy disagreement inside the ring.

Top module: `dly_update_queue`

## Requirements
- R1: After reset every register reads zero, the ring is empty, `queueFull` is low and `ptrFault` is low.
- R2: While `queueFull` is low, an asserted `enqValid` stores one entry. `queueFull` is high exactly when all `NUM_SLOTS` entries are occupied. An enqueue while full is dropped: it has no effect on any register and it takes no slot.
- R3: An entry enqueued with delay d applies its update on the clock edge of the d-th tick after the enqueue edge. A delay of 0 behaves as 1. The new value is seen on `rdData` right after that edge.
- R4: Word update (`enqBitOp`=0). With `enqWide`=1, all 64 bits of the destination are replaced. With `enqWide`=0, only bits 31:0 are replaced and bits 63:32 keep their value.
- R5: Bit update (`enqBitOp`=1). The selected bit is set when `enqValue` is nonzero and cleared when it is zero, and every other bit is left unchanged. The bit number is `enqBitIdx` (0..63) when `enqWide`=1, and `enqBitIdx[4:0]` when `enqWide`=0.
- R6: Entries are freed only from the head of the ring. An entry that matured behind a head that has not yet matured still applies its update, but it keeps its slot (and `queueFull` stays high) until the head matures. Both are then freed on the same tick.
- R7: When several entries mature on the same tick, their updates are applied in ring order starting at the head. If they target the same register, the youngest one decides the result.
- R8: An enqueue and a tick in the same cycle are both honoured. The newly stored entry is not counted down by that tick.
- R9: Without a tick, no entry counts down, matures or is freed.
- R10: `ptrFault` goes high and stays high if the read and write pointers differ while the occupancy is zero. In correct operation it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Push one pending update |
| enqDest | input | REG_W | Destination register index |
| enqDelay | input | DELAY_W | Ticks until the update applies (0 treated as 1) |
| enqBitOp | input | 1 | 0 = word write, 1 = single-bit set/clear |
| enqBitIdx | input | 6 | Bit number for bit updates |
| enqWide | input | 1 | 1 = 64-bit size, 0 = 32-bit size |
| enqValue | input | 64 | Word data, or nonzero/zero selector for bit updates |
| queueFull | output | 1 | All slots occupied; enqueues are dropped |
| tick | input | 1 | Count down all waiting entries this cycle |
| rdAddr | input | REG_W | Register read address |
| rdData | output | 64 | Contents of the addressed register |
| ptrFault | output | 1 | Sticky pointer/occupancy mismatch flag |

## Verification
The bench builds the block with its defaults: four slots, eight registers and a 4-bit delay. With only four slots, the ring fills, rejects and wraps its pointers within a handful of enqueues. With eight registers, random traffic often sends several entries to the same register. A 4-bit delay allows entries with long delays to sit in front of short ones, which drives the in-order retirement path and the same-tick collision ordering. The random phase is compared against a cycle-level model of the requirements on every cycle.

// File: rtl/duq_pkg.sv
`timescale 1ns/1ps
package duq_pkg;

  localparam int VAL_W     = 64;
  localparam int BIT_IDX_W = 6;

  typedef enum logic { SZ_NARROW = 1'b0, SZ_WIDE = 1'b1 } updSize_e;
  typedef enum logic { UPD_WORD = 1'b0, UPD_BIT = 1'b1 } updKind_e;

  typedef struct packed {
    updKind_e               kind;
    updSize_e               size;
    logic [BIT_IDX_W-1:0]   bitIdx;
    logic [VAL_W-1:0]       value;
  } updPayload_t;

  // strobes from control to datapath
  typedef struct packed {
    logic enqWr;
    logic tickEn;
  } ctrlStrobe_t;

  // position ofs steps past base in a ring of depth entries
  function automatic int ringStep(int base, int ofs, int depth);
    int s;
    s = base + ofs;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // apply one matured update to the current register contents
  function automatic logic [VAL_W-1:0] applyUpdate(logic [VAL_W-1:0] cur, updPayload_t p);
    logic [BIT_IDX_W-1:0] b;
    logic [VAL_W-1:0]     mask;
    logic [VAL_W-1:0]     res;
    b    = (p.size == SZ_WIDE) ? p.bitIdx : {1'b0, p.bitIdx[BIT_IDX_W-2:0]};
    mask = {{(VAL_W-1){1'b0}}, 1'b1} << b;
    if (p.kind == UPD_BIT)
      res = (p.value != '0) ? (cur | mask) : (cur & ~mask);
    else if (p.size == SZ_WIDE)
      res = p.value;
    else
      res = {cur[VAL_W-1:32], p.value[31:0]};
    return res;
  endfunction

endpackage

// File: rtl/duq_ctrl.sv
`timescale 1ns/1ps
module duq_ctrl
  import duq_pkg::*;
#(
  parameter  int NUM_SLOTS = 4,
  localparam int PTR_W     = $clog2(NUM_SLOTS),
  localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enqValid,
  input  logic                 tick,
  input  logic [NUM_SLOTS-1:0] slotLive,
  input  logic [NUM_SLOTS-1:0] slotDoneNext,
  output ctrlStrobe_t          strobes,
  output logic [PTR_W-1:0]     inPtr,
  output logic [PTR_W-1:0]     outPtr,
  output logic [CNT_W-1:0]     occCount,
  output logic [NUM_SLOTS-1:0] retireMask,
  output logic                 queueFull,
  output logic                 ptrFault
);

  logic [PTR_W-1:0] inPtrQ, outPtrQ;
  logic [CNT_W-1:0] countQ;
  logic             faultQ;
  logic             enqAccept;
  logic [CNT_W-1:0] retireCnt;
  logic [PTR_W-1:0] scanIdx;
  logic             scanBlocked;

  assign queueFull      = (countQ == CNT_W'(NUM_SLOTS));
  assign enqAccept      = enqValid & ~queueFull;
  assign strobes.enqWr  = enqAccept;
  assign strobes.tickEn = tick;

  // free the contiguous run of finished entries starting at the head
  always_comb begin
    retireMask  = '0;
    retireCnt   = '0;
    scanBlocked = 1'b0;
    scanIdx     = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      scanIdx = PTR_W'(ringStep(int'(outPtrQ), k, NUM_SLOTS));
      if (!scanBlocked && tick && slotLive[scanIdx] && slotDoneNext[scanIdx]) begin
        retireMask[scanIdx] = 1'b1;
        retireCnt           = retireCnt + CNT_W'(1);
      end else begin
        scanBlocked = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inPtrQ  <= '0;
      outPtrQ <= '0;
      countQ  <= '0;
      faultQ  <= 1'b0;
    end else begin
      if (enqAccept)
        inPtrQ <= PTR_W'(ringStep(int'(inPtrQ), 1, NUM_SLOTS));
      outPtrQ <= PTR_W'(ringStep(int'(outPtrQ), int'(retireCnt), NUM_SLOTS));
      countQ  <= countQ + CNT_W'(enqAccept) - retireCnt;
      if ((inPtrQ != outPtrQ) && (countQ == '0))
        faultQ <= 1'b1;
    end
  end

  assign inPtr    = inPtrQ;
  assign outPtr   = outPtrQ;
  assign occCount = countQ;
  assign ptrFault = faultQ;

endmodule

// File: rtl/duq_datapath.sv
`timescale 1ns/1ps
module duq_datapath
  import duq_pkg::*;
#(
  parameter  int NUM_SLOTS = 4,
  parameter  int NUM_REGS  = 8,
  parameter  int DELAY_W   = 4,
  localparam int PTR_W     = $clog2(NUM_SLOTS),
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strobes,
  input  logic [PTR_W-1:0]     inPtr,
  input  logic [PTR_W-1:0]     outPtr,
  input  logic [NUM_SLOTS-1:0] retireMask,
  input  logic [REG_W-1:0]     enqDest,
  input  logic [DELAY_W-1:0]   enqDelay,
  input  updPayload_t          enqPayload,
  output logic [NUM_SLOTS-1:0] slotLive,
  output logic [NUM_SLOTS-1:0] slotDoneNext,
  input  logic [REG_W-1:0]     rdAddr,
  output logic [VAL_W-1:0]     rdData
);

  logic [NUM_SLOTS-1:0] liveQ, doneQ, matureNow;
  logic [DELAY_W-1:0]   cntQ [NUM_SLOTS];
  logic [REG_W-1:0]     dstQ [NUM_SLOTS];
  updPayload_t          payQ [NUM_SLOTS];
  logic [VAL_W-1:0]     regQ [NUM_REGS];
  logic [VAL_W-1:0]     regD [NUM_REGS];
  logic [PTR_W-1:0]     applyIdx;

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      matureNow[s]    = strobes.tickEn & liveQ[s] & ~doneQ[s] & (cntQ[s] <= DELAY_W'(1));
      slotDoneNext[s] = liveQ[s] & (doneQ[s] | matureNow[s]);
    end
  end

  assign slotLive = liveQ;

  // slot storage and parallel countdown
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      liveQ <= '0;
      doneQ <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        cntQ[s] <= '0;
        dstQ[s] <= '0;
        payQ[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (strobes.enqWr && (inPtr == PTR_W'(s))) begin
          liveQ[s] <= 1'b1;
          doneQ[s] <= 1'b0;
          cntQ[s]  <= enqDelay;
          dstQ[s]  <= enqDest;
          payQ[s]  <= enqPayload;
        end else if (retireMask[s]) begin
          liveQ[s] <= 1'b0;
          doneQ[s] <= 1'b0;
        end else if (matureNow[s]) begin
          doneQ[s] <= 1'b1;
          cntQ[s]  <= '0;
        end else if (strobes.tickEn && liveQ[s] && !doneQ[s]) begin
          cntQ[s]  <= cntQ[s] - DELAY_W'(1);
        end
      end
    end
  end

  // matured updates applied in ring order from the head; later ones win
  always_comb begin
    applyIdx = '0;
    for (int r = 0; r < NUM_REGS; r++) regD[r] = regQ[r];
    for (int k = 0; k < NUM_SLOTS; k++) begin
      applyIdx = PTR_W'(ringStep(int'(outPtr), k, NUM_SLOTS));
      if (matureNow[applyIdx])
        regD[dstQ[applyIdx]] = applyUpdate(regD[dstQ[applyIdx]], payQ[applyIdx]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) regQ[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) regQ[r] <= regD[r];
    end
  end

  assign rdData = regQ[rdAddr];

endmodule

// File: rtl/dly_update_queue.sv
`timescale 1ns/1ps
module dly_update_queue
  import duq_pkg::*;
#(
  parameter  int NUM_SLOTS = 4,
  parameter  int NUM_REGS  = 8,
  parameter  int DELAY_W   = 4,
  localparam int PTR_W     = $clog2(NUM_SLOTS),
  localparam int CNT_W     = $clog2(NUM_SLOTS + 1),
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enqValid,
  input  logic [REG_W-1:0]     enqDest,
  input  logic [DELAY_W-1:0]   enqDelay,
  input  logic                 enqBitOp,
  input  logic [BIT_IDX_W-1:0] enqBitIdx,
  input  logic                 enqWide,
  input  logic [VAL_W-1:0]     enqValue,
  output logic                 queueFull,
  input  logic                 tick,
  input  logic [REG_W-1:0]     rdAddr,
  output logic [VAL_W-1:0]     rdData,
  output logic                 ptrFault
);

  ctrlStrobe_t          strobes;
  updPayload_t          enqPayload;
  logic [PTR_W-1:0]     inPtr, outPtr;
  logic [CNT_W-1:0]     occCount;
  logic [NUM_SLOTS-1:0] retireMask, slotLive, slotDoneNext;

  assign enqPayload.kind   = enqBitOp ? UPD_BIT : UPD_WORD;
  assign enqPayload.size   = enqWide ? SZ_WIDE : SZ_NARROW;
  assign enqPayload.bitIdx = enqBitIdx;
  assign enqPayload.value  = enqValue;

  duq_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enqValid     (enqValid),
    .tick         (tick),
    .slotLive     (slotLive),
    .slotDoneNext (slotDoneNext),
    .strobes      (strobes),
    .inPtr        (inPtr),
    .outPtr       (outPtr),
    .occCount     (occCount),
    .retireMask   (retireMask),
    .queueFull    (queueFull),
    .ptrFault     (ptrFault)
  );

  duq_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_REGS  (NUM_REGS),
    .DELAY_W   (DELAY_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .inPtr        (inPtr),
    .outPtr       (outPtr),
    .retireMask   (retireMask),
    .enqDest      (enqDest),
    .enqDelay     (enqDelay),
    .enqPayload   (enqPayload),
    .slotLive     (slotLive),
    .slotDoneNext (slotDoneNext),
    .rdAddr       (rdAddr),
    .rdData       (rdData)
  );

endmodule

// File: rtl/duq_checker.sv
`timescale 1ns/1ps
module duq_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int PTR_W     = 2,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enqValid,
  input logic             tick,
  input logic             queueFull,
  input logic [PTR_W-1:0] inPtr,
  input logic [PTR_W-1:0] outPtr,
  input logic [CNT_W-1:0] occCount,
  input logic             ptrFault
);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occCount <= CNT_W'(NUM_SLOTS));

  a_r2_reject_full: assert property (@(posedge clk) disable iff (!rst_n)
    (queueFull && enqValid) |=> (inPtr == $past(inPtr)));

  a_r2_accept_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (enqValid && !queueFull) |=> (inPtr != $past(inPtr)));

  a_r9_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(outPtr));

  a_r9_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !enqValid) |=> $stable(occCount));

  a_r10_ptr_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (inPtr != outPtr) |-> (occCount != '0));

  a_r10_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !ptrFault);

endmodule

bind dly_update_queue duq_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .PTR_W     (PTR_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enqValid  (enqValid),
  .tick      (tick),
  .queueFull (queueFull),
  .inPtr     (inPtr),
  .outPtr    (outPtr),
  .occCount  (occCount),
  .ptrFault  (ptrFault)
);

// File: tb/dly_update_queue_bench.sv
`timescale 1ns/1ps
module dly_update_queue_bench;

  localparam int N    = 4;
  localparam int REGS = 8;
  localparam int DW   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enqValid = 1'b0;
  logic [2:0]  enqDest = '0;
  logic [DW-1:0] enqDelay = '0;
  logic        enqBitOp = 1'b0;
  logic [5:0]  enqBitIdx = '0;
  logic        enqWide = 1'b0;
  logic [63:0] enqValue = '0;
  logic        queueFull;
  logic        tick = 1'b0;
  logic [2:0]  rdAddr = '0;
  logic [63:0] rdData;
  logic        ptrFault;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // model state
  bit          mLive [N];
  bit          mDone [N];
  int          mCnt  [N];
  logic [2:0]  mDst  [N];
  bit          mBit  [N];
  bit          mWide [N];
  logic [5:0]  mIdx  [N];
  logic [63:0] mVal  [N];
  logic [63:0] mRegs [REGS];
  int mIn = 0, mOut = 0, mCount = 0;

  always #4 clk = ~clk;

  dly_update_queue u_dly_update_queue (
    .clk(clk), .rst_n(rst_n), .enqValid(enqValid), .enqDest(enqDest),
    .enqDelay(enqDelay), .enqBitOp(enqBitOp), .enqBitIdx(enqBitIdx),
    .enqWide(enqWide), .enqValue(enqValue), .queueFull(queueFull),
    .tick(tick), .rdAddr(rdAddr), .rdData(rdData), .ptrFault(ptrFault)
  );

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] modelApply(logic [63:0] cur, bit isBit, bit wide,
                                             logic [5:0] idx, logic [63:0] v);
    int b;
    b = wide ? int'(idx) : int'(idx[4:0]);
    if (isBit) begin
      if (v != 0) cur[b] = 1'b1; else cur[b] = 1'b0;
      return cur;
    end
    if (wide) return v;
    return {cur[63:32], v[31:0]};
  endfunction

  task automatic modelStep(bit ev, logic [2:0] d, int dl, bit bo, logic [5:0] bi,
                           bit w, logic [63:0] v, bit tk);
    bit acc;
    acc = ev && (mCount != N);
    if (tk) begin
      for (int k = 0; k < N; k++) begin
        int i;
        i = (mOut + k) % N;
        if (mLive[i] && !mDone[i]) begin
          if (mCnt[i] <= 1) begin
            mRegs[mDst[i]] = modelApply(mRegs[mDst[i]], mBit[i], mWide[i], mIdx[i], mVal[i]);
            mDone[i] = 1'b1;
          end else mCnt[i]--;
        end
      end
      while (mCount > 0 && mDone[mOut]) begin
        mLive[mOut] = 1'b0; mDone[mOut] = 1'b0;
        mOut = (mOut + 1) % N; mCount--;
      end
    end
    if (acc) begin
      mLive[mIn] = 1'b1; mDone[mIn] = 1'b0; mCnt[mIn] = dl; mDst[mIn] = d;
      mBit[mIn] = bo; mWide[mIn] = w; mIdx[mIn] = bi; mVal[mIn] = v;
      mIn = (mIn + 1) % N; mCount++;
    end
  endtask

  task automatic compareAll(string req);
    for (int r = 0; r < REGS; r++) begin
      rdAddr = 3'(r);
      #0.2;
      check64(req, $sformatf("reg%0d vs model", r), rdData, mRegs[r]);
    end
    check64(req, "queueFull vs model", 64'(queueFull), 64'(mCount == N));
    check64("R10", "ptrFault", 64'(ptrFault), 64'd0);
  endtask

  // one cycle: drive at negedge, apply at posedge, compare at next negedge
  task automatic step(string req, bit ev, logic [2:0] d, int dl, bit bo, logic [5:0] bi,
                      bit w, logic [63:0] v, bit tk);
    enqValid = ev; enqDest = d; enqDelay = DW'(dl); enqBitOp = bo;
    enqBitIdx = bi; enqWide = w; enqValue = v; tick = tk;
    modelStep(ev, d, dl, bo, bi, w, v, tk);
    @(posedge clk);
    @(negedge clk);
    enqValid = 1'b0; tick = 1'b0;
    compareAll(req);
  endtask

  task automatic enqW(string req, logic [2:0] d, int dl, bit w, logic [63:0] v);
    step(req, 1'b1, d, dl, 1'b0, 6'd0, w, v, 1'b0);
  endtask

  task automatic enqB(string req, logic [2:0] d, int dl, bit w, logic [5:0] bi, logic [63:0] v);
    step(req, 1'b1, d, dl, 1'b1, bi, w, v, 1'b0);
  endtask

  task automatic tk(string req);
    step(req, 1'b0, 3'd0, 0, 1'b0, 6'd0, 1'b0, 64'd0, 1'b1);
  endtask

  task automatic idle(string req);
    step(req, 1'b0, 3'd0, 0, 1'b0, 6'd0, 1'b0, 64'd0, 1'b0);
  endtask

  task automatic expectReg(string req, int a, logic [63:0] exp);
    rdAddr = 3'(a);
    #0.2;
    check64(req, $sformatf("reg%0d", a), rdData, exp);
  endtask

  task automatic expectFull(string req, bit exp);
    check64(req, "queueFull", 64'(queueFull), 64'(exp));
  endtask

  task automatic drain(string req);
    for (int g = 0; g < 40 && mCount > 0; g++) tk(req);
    check64(req, "drained", 64'(mCount), 64'd0);
  endtask

  task automatic tReset();
    compareAll("R1");
    for (int r = 0; r < REGS; r++) expectReg("R1", r, 64'd0);
    expectFull("R1", 1'b0);
    check64("R1", "ptrFault", 64'(ptrFault), 64'd0);
  endtask

  task automatic tWordWrites();
    enqW("R3", 3'd1, 3, 1'b1, 64'hA5A5_0F0F_C3C3_9696);
    tk("R3"); expectReg("R3", 1, 64'd0);
    tk("R3"); expectReg("R3", 1, 64'd0);
    tk("R3"); expectReg("R3", 1, 64'hA5A5_0F0F_C3C3_9696);
    enqW("R4", 3'd1, 1, 1'b0, 64'hFFFF_FFFF_1234_5678);
    tk("R4"); expectReg("R4", 1, 64'hA5A5_0F0F_1234_5678);
  endtask

  task automatic tBitOps();
    enqB("R5", 3'd2, 1, 1'b1, 6'd40, 64'd1);
    tk("R5"); expectReg("R5", 2, 64'h0000_0100_0000_0000);
    enqB("R5", 3'd2, 1, 1'b0, 6'd37, 64'd7);
    tk("R5"); expectReg("R5", 2, 64'h0000_0100_0000_0020);
    enqB("R5", 3'd2, 1, 1'b1, 6'd40, 64'd0);
    tk("R5"); expectReg("R5", 2, 64'h0000_0000_0000_0020);
  endtask

  task automatic tInOrder();
    enqW("R6", 3'd3, 5, 1'b1, 64'h33);
    enqW("R6", 3'd4, 1, 1'b1, 64'h44);
    enqW("R6", 3'd5, 6, 1'b1, 64'h55);
    enqW("R6", 3'd6, 6, 1'b1, 64'h66);
    expectFull("R2", 1'b1);
    tk("R6"); expectReg("R6", 4, 64'h44); expectFull("R6", 1'b1);
    tk("R6"); tk("R6"); tk("R6");
    expectFull("R6", 1'b1); expectReg("R6", 3, 64'd0);
    tk("R6"); expectReg("R6", 3, 64'h33); expectFull("R6", 1'b0);
    drain("R6");
  endtask

  task automatic tRejectFull();
    enqW("R7", 3'd0, 8, 1'b1, 64'h10);
    enqW("R7", 3'd0, 8, 1'b1, 64'h11);
    enqW("R7", 3'd0, 8, 1'b1, 64'h12);
    enqW("R7", 3'd0, 8, 1'b1, 64'h13);
    expectFull("R2", 1'b1);
    enqW("R2", 3'd6, 1, 1'b1, 64'hDEAD);
    expectFull("R2", 1'b1);
    drain("R2");
    expectReg("R2", 6, 64'h66);
    expectReg("R7", 0, 64'h13);
  endtask

  task automatic tSameTick();
    enqW("R7", 3'd5, 3, 1'b1, 64'h111);
    enqW("R7", 3'd5, 3, 1'b1, 64'h222);
    tk("R7"); tk("R7"); tk("R7");
    expectReg("R7", 5, 64'h222);
  endtask

  task automatic tEnqWithTick();
    enqW("R8", 3'd1, 2, 1'b1, 64'h77);
    step("R8", 1'b1, 3'd2, 1, 1'b0, 6'd0, 1'b1, 64'h88, 1'b1);
    expectReg("R8", 2, 64'h20);
    expectReg("R8", 1, 64'hA5A5_0F0F_1234_5678);
    tk("R8");
    expectReg("R8", 1, 64'h77);
    expectReg("R8", 2, 64'h88);
  endtask

  task automatic tIdleAndZero();
    enqW("R9", 3'd3, 1, 1'b1, 64'h99);
    for (int c = 0; c < 5; c++) idle("R9");
    expectReg("R9", 3, 64'h33);
    tk("R9"); expectReg("R9", 3, 64'h99);
    enqW("R3", 3'd4, 0, 1'b1, 64'h4040);
    tk("R3"); expectReg("R3", 4, 64'h4040);
  endtask

  task automatic tRandom();
    for (int c = 0; c < 600; c++) begin
      step("R7", ($urandom % 3) != 0, 3'($urandom % 8), int'($urandom % 6),
           1'($urandom % 2), 6'($urandom % 64), 1'($urandom % 2),
           (($urandom % 4) == 0) ? 64'd0 : {$urandom, $urandom}, 1'($urandom % 2));
    end
    drain("R6");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mLive[i] = 0; mDone[i] = 0; mCnt[i] = 0; mDst[i] = '0;
      mBit[i] = 0; mWide[i] = 0; mIdx[i] = '0; mVal[i] = '0;
    end
    for (int r = 0; r < REGS; r++) mRegs[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tReset();
    tWordWrites();
    tBitOps();
    tInOrder();
    tRejectFull();
    tSameTick();
    tEnqWithTick();
    tIdleAndZero();
    tRandom();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule